// File: doc/BRIEF.md
# Task Pointer Doorbell Receiver

This block is a 16-bit bus-slave register port. A remote processor uses it to hand the local host the location of a task control block. The remote side posts an 18-bit word pointer by raising a post line. The block captures the pointer and sets a new-pointer flag. If the host has enabled interrupts, it also raises a host interrupt.

The host reaches the port through three word registers chosen by a two-bit register select:
- 0 is the control/status register.
- 1 is the output buffer.
- 2 is the input buffer.
- Select 3 is not decoded.

Reading the input buffer is destructive. The read returns the pointer converted from a word address to a byte address. It also clears the flag and the interrupt, and it sends a one-cycle acknowledge back to the poster.

Writes to the output buffer complete work in the other direction. Each write raises a vector request on level 2, level 3 or both, carrying the written bytes.

Top module: `tpd_doorbell_rx`

## Requirements
- R1: After reset, the host interrupt, acknowledge, error and both level requests are low, and a status read returns 0.
- R2: A post, meaning the post line rising from low to high, latches the 18-bit pointer and sets the new-pointer flag. The flag reads back as status bit 7 one cycle later. The host interrupt rises in that same cycle only if interrupt enable is set.
- R3: A read at select 2 returns the latched pointer shifted left by one and truncated to 16 bits.
- R4: A read at select 2 clears the flag and the host interrupt. It also pulses the remote acknowledge high for exactly one cycle.
- R5: A status write (select 0, even byte or full word) changes only interrupt enable, which is status bit 6. Writing 0 drops the interrupt. Writing 1 while the flag is set raises it. An odd-byte status write has no effect.
- R6: At select 1, a full-word write issues a level 3 request carrying bits 15:8 and a level 2 request carrying bits 7:0. An odd-byte write issues only level 3, carrying bits 15:8. An even-byte write issues only level 2, carrying bits 7:0. Each request lasts one cycle.
- R7: Holding the post line high produces exactly one flag set. After a clearing read, the flag stays clear while the line remains high.
- R8: If a post and a read at select 2 fall in the same cycle, the post wins. The flag stays set, and the read returns the previously latched pointer.
- R9: Any access at select 3 pulses the error output for one cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| host_sel | input | 2 | Register select |
| host_odd | input | 1 | Odd byte address for byte accesses |
| host_byte | input | 1 | 1 = byte access, 0 = full word |
| host_rd | input | 1 | Read strobe, one cycle per access |
| host_wr | input | 1 | Write strobe, one cycle per access |
| host_wdata | input | 16 | Write data |
| host_rdata | output | 16 | Read data, registered |
| host_err | output | 1 | Nonexistent-register pulse |
| host_irq | output | 1 | Host interrupt |
| post_in | input | 1 | Remote post line, acts on its rising edge |
| post_ptr | input | 18 | Remote word pointer |
| remote_ack | output | 1 | Pointer-read acknowledge pulse |
| req2_valid | output | 1 | Level 2 request pulse |
| req2_vec | output | 8 | Level 2 vector |
| req3_valid | output | 1 | Level 3 request pulse |
| req3_vec | output | 8 | Level 3 vector |

## Verification
Every result of this block is registered once. Read data, error, acknowledge, level requests, the flag and the interrupt therefore all appear in the cycle after the clock edge that samples a strobe or a post.

The bench drives each stimulus on a falling edge and removes it on the next falling edge. It samples the outputs at that same point, which is one full cycle after the stimulus. Each one-cycle pulse is then checked again one falling edge later to confirm that it has dropped.

// File: rtl/tpd_pkg.sv
package tpd_pkg;
  localparam int DATA_W   = 16;
  localparam int PTR_W    = 18;
  localparam int VEC_W    = 8;
  localparam int FLAG_BIT = 7;
  localparam int IE_BIT   = 6;

  typedef enum logic [1:0] {
    SEL_CSR  = 2'd0,
    SEL_OBUF = 2'd1,
    SEL_IBUF = 2'd2,
    SEL_NONE = 2'd3
  } tpd_sel_e;

  // word pointer to byte pointer: one left shift, kept to the bus width
  function automatic logic [DATA_W-1:0] ptr_to_byte(input logic [PTR_W-1:0] p);
    return DATA_W'({p, 1'b0});
  endfunction

  function automatic logic [DATA_W-1:0] csr_pack(input logic flag, input logic ie);
    logic [DATA_W-1:0] r;
    r = '0;
    r[FLAG_BIT] = flag;
    r[IE_BIT]   = ie;
    return r;
  endfunction
endpackage

// File: rtl/tpd_post_detect.sv
module tpd_post_detect #(
  parameter int PTR_W = tpd_pkg::PTR_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             post_in,
  input  logic [PTR_W-1:0] post_ptr,
  output logic             post_ev,
  output logic [PTR_W-1:0] ptr_q
);
  logic post_q;

  // a held post line is consumed once: only its rising edge counts
  assign post_ev = post_in & ~post_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      post_q <= 1'b0;
      ptr_q  <= '0;
    end else begin
      post_q <= post_in;
      if (post_ev) ptr_q <= post_ptr;
    end
  end
endmodule

// File: rtl/tpd_vec_out.sv
module tpd_vec_out #(
  parameter int DATA_W = tpd_pkg::DATA_W,
  parameter int VEC_W  = tpd_pkg::VEC_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_obuf,
  input  logic              byte_acc,
  input  logic              odd,
  input  logic [DATA_W-1:0] wdata,
  output logic              lo_req,
  output logic [VEC_W-1:0]  lo_vec,
  output logic              hi_req,
  output logic [VEC_W-1:0]  hi_vec
);
  localparam int LANES = DATA_W / VEC_W;

  logic [LANES-1:0]            fire;
  logic [LANES-1:0]            req_q;
  logic [LANES-1:0][VEC_W-1:0] vec_q;

  // lane 0 = even byte (level 2), lane 1 = odd byte (level 3)
  assign fire[0] = wr_obuf & ~(byte_acc & odd);
  assign fire[1] = wr_obuf & (~byte_acc | odd);

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        req_q[g] <= 1'b0;
        vec_q[g] <= '0;
      end else begin
        req_q[g] <= fire[g];
        if (fire[g]) vec_q[g] <= wdata[g*VEC_W +: VEC_W];
      end
    end
  end

  assign lo_req = req_q[0];
  assign lo_vec = vec_q[0];
  assign hi_req = req_q[LANES-1];
  assign hi_vec = vec_q[LANES-1];
endmodule

// File: rtl/tpd_host_regs.sv
module tpd_host_regs
  import tpd_pkg::*;
#(
  parameter int DATA_W = tpd_pkg::DATA_W,
  parameter int PTR_W  = tpd_pkg::PTR_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  tpd_sel_e          sel,
  input  logic              odd,
  input  logic              byte_acc,
  input  logic              rd,
  input  logic              wr,
  input  logic              ie_wbit,
  input  logic              post_ev,
  input  logic [PTR_W-1:0]  ptr_q,
  output logic [DATA_W-1:0] rdata,
  output logic              err,
  output logic              irq,
  output logic              ack,
  output logic              flag,
  output logic              ie,
  output logic              ptr_read_ev,
  output logic              wr_obuf
);
  logic csr_wr;
  logic ie_n;
  logic flag_n;

  assign csr_wr      = wr & (sel == SEL_CSR) & ~(byte_acc & odd);
  assign wr_obuf     = wr & (sel == SEL_OBUF);
  assign ptr_read_ev = rd & (sel == SEL_IBUF);

  always_comb begin
    ie_n = csr_wr ? ie_wbit : ie;
    if (post_ev)          flag_n = 1'b1;
    else if (ptr_read_ev) flag_n = 1'b0;
    else                  flag_n = flag;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      flag  <= 1'b0;
      ie    <= 1'b0;
      irq   <= 1'b0;
      ack   <= 1'b0;
      err   <= 1'b0;
      rdata <= '0;
    end else begin
      flag <= flag_n;
      ie   <= ie_n;
      irq  <= flag_n & ie_n;
      ack  <= ptr_read_ev;
      err  <= (rd | wr) & (sel == SEL_NONE);
      if (rd) begin
        unique case (sel)
          SEL_CSR:  rdata <= csr_pack(flag, ie);
          SEL_IBUF: rdata <= ptr_to_byte(ptr_q);
          default:  rdata <= '0;
        endcase
      end
    end
  end
endmodule

// File: rtl/tpd_doorbell_rx.sv
module tpd_doorbell_rx
  import tpd_pkg::*;
#(
  parameter int DATA_W = tpd_pkg::DATA_W,
  parameter int PTR_W  = tpd_pkg::PTR_W,
  parameter int VEC_W  = tpd_pkg::VEC_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [1:0]        host_sel,
  input  logic              host_odd,
  input  logic              host_byte,
  input  logic              host_rd,
  input  logic              host_wr,
  input  logic [DATA_W-1:0] host_wdata,
  output logic [DATA_W-1:0] host_rdata,
  output logic              host_err,
  output logic              host_irq,
  input  logic              post_in,
  input  logic [PTR_W-1:0]  post_ptr,
  output logic              remote_ack,
  output logic              req2_valid,
  output logic [VEC_W-1:0]  req2_vec,
  output logic              req3_valid,
  output logic [VEC_W-1:0]  req3_vec
);
  // named internal events, brought out for the checker
  logic             post_ev;
  logic             ptr_read_ev;
  logic             wr_obuf;
  logic             new_flag;
  logic             ie;
  logic [PTR_W-1:0] ptr_q;

  tpd_post_detect #(.PTR_W(PTR_W)) u_post (
    .clk(clk), .rst_n(rst_n), .post_in(post_in), .post_ptr(post_ptr),
    .post_ev(post_ev), .ptr_q(ptr_q)
  );

  tpd_host_regs #(.DATA_W(DATA_W), .PTR_W(PTR_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .sel(tpd_sel_e'(host_sel)), .odd(host_odd),
    .byte_acc(host_byte), .rd(host_rd), .wr(host_wr),
    .ie_wbit(host_wdata[IE_BIT]), .post_ev(post_ev), .ptr_q(ptr_q),
    .rdata(host_rdata), .err(host_err), .irq(host_irq), .ack(remote_ack),
    .flag(new_flag), .ie(ie), .ptr_read_ev(ptr_read_ev), .wr_obuf(wr_obuf)
  );

  tpd_vec_out #(.DATA_W(DATA_W), .VEC_W(VEC_W)) u_vec (
    .clk(clk), .rst_n(rst_n), .wr_obuf(wr_obuf), .byte_acc(host_byte),
    .odd(host_odd), .wdata(host_wdata),
    .lo_req(req2_valid), .lo_vec(req2_vec),
    .hi_req(req3_valid), .hi_vec(req3_vec)
  );
endmodule

// File: rtl/tpd_doorbell_rx_chk.sv
module tpd_doorbell_rx_chk (
  input logic       clk,
  input logic       rst_n,
  input logic [1:0] host_sel,
  input logic       host_rd,
  input logic       host_wr,
  input logic       host_byte,
  input logic       host_err,
  input logic       host_irq,
  input logic       remote_ack,
  input logic       req2_valid,
  input logic       req3_valid,
  input logic       post_ev,
  input logic       ptr_read_ev,
  input logic       new_flag,
  input logic       ie
);
  a_r2_post_sets_flag: assert property (@(posedge clk) disable iff (!rst_n)
    post_ev |=> new_flag);

  a_r4_read_clears_flag: assert property (@(posedge clk) disable iff (!rst_n)
    (ptr_read_ev && !post_ev) |=> (!new_flag && !host_irq));

  a_r4_ack_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    remote_ack |=> !remote_ack);

  a_r4_ack_follows_read: assert property (@(posedge clk) disable iff (!rst_n)
    ptr_read_ev |=> remote_ack);

  a_r5_irq_gated: assert property (@(posedge clk) disable iff (!rst_n)
    host_irq |-> (new_flag && ie));

  a_r6_word_both_levels: assert property (@(posedge clk) disable iff (!rst_n)
    (host_wr && host_sel == 2'd1 && !host_byte) |=> (req2_valid && req3_valid));

  a_r7_post_once: assert property (@(posedge clk) disable iff (!rst_n)
    post_ev |=> !post_ev);

  a_r8_post_wins: assert property (@(posedge clk) disable iff (!rst_n)
    (post_ev && ptr_read_ev) |=> new_flag);

  a_r9_nxm_error: assert property (@(posedge clk) disable iff (!rst_n)
    ((host_rd || host_wr) && host_sel == 2'd3) |=> host_err);
endmodule

bind tpd_doorbell_rx tpd_doorbell_rx_chk u_chk (
  .clk(clk), .rst_n(rst_n), .host_sel(host_sel), .host_rd(host_rd),
  .host_wr(host_wr), .host_byte(host_byte), .host_err(host_err),
  .host_irq(host_irq), .remote_ack(remote_ack), .req2_valid(req2_valid),
  .req3_valid(req3_valid), .post_ev(post_ev), .ptr_read_ev(ptr_read_ev),
  .new_flag(new_flag), .ie(ie)
);

// File: tb/tpd_doorbell_rx_tb.sv
module tpd_doorbell_rx_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [1:0]  host_sel = '0;
  logic        host_odd = 1'b0;
  logic        host_byte = 1'b0;
  logic        host_rd = 1'b0;
  logic        host_wr = 1'b0;
  logic [15:0] host_wdata = '0;
  logic [15:0] host_rdata;
  logic        host_err;
  logic        host_irq;
  logic        post_in = 1'b0;
  logic [17:0] post_ptr = '0;
  logic        remote_ack;
  logic        req2_valid;
  logic [7:0]  req2_vec;
  logic        req3_valid;
  logic [7:0]  req3_vec;

  int n_tests = 0;
  int n_fail  = 0;
  bit done    = 1'b0;

  always #5 clk = ~clk;

  tpd_doorbell_rx u_dut (
    .clk(clk), .rst_n(rst_n), .host_sel(host_sel), .host_odd(host_odd),
    .host_byte(host_byte), .host_rd(host_rd), .host_wr(host_wr),
    .host_wdata(host_wdata), .host_rdata(host_rdata), .host_err(host_err),
    .host_irq(host_irq), .post_in(post_in), .post_ptr(post_ptr),
    .remote_ack(remote_ack), .req2_valid(req2_valid), .req2_vec(req2_vec),
    .req3_valid(req3_valid), .req3_vec(req3_vec)
  );

  task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
    n_tests++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got %0h expected %0h", req, got, exp);
    end
  endtask

  // word address to byte address, restated by multiplication
  function automatic logic [15:0] exp_byte_ptr(input logic [17:0] w);
    int unsigned v;
    v = (int'(w) * 2) % 65536;
    return v[15:0];
  endfunction

  // one bus cycle: driven at a falling edge, results sampled one cycle later
  task automatic bus(input logic [1:0] sel, input logic rd, input logic wr,
                     input logic byt, input logic odd, input logic [15:0] wd);
    @(negedge clk);
    host_sel = sel; host_rd = rd; host_wr = wr;
    host_byte = byt; host_odd = odd; host_wdata = wd;
    @(negedge clk);
    host_rd = 1'b0; host_wr = 1'b0;
  endtask

  task automatic post(input logic [17:0] p);
    @(negedge clk);
    post_in = 1'b1; post_ptr = p;
    @(negedge clk);
    post_in = 1'b0;
  endtask

  task automatic t_reset();
    check("R1 irq", host_irq, 0);
    check("R1 ack", remote_ack, 0);
    check("R1 err", host_err, 0);
    check("R1 req", {req2_valid, req3_valid}, 0);
    bus(2'd0, 1, 0, 0, 0, 0);
    check("R1 status", host_rdata, 0);
  endtask

  task automatic t_post_read();
    logic [17:0] p;
    p = 18'h2ABCD;
    post(p);
    check("R2 irq off when IE=0", host_irq, 0);
    bus(2'd0, 1, 0, 0, 0, 0);
    check("R2 flag bit7", host_rdata, 16'h0080);
    bus(2'd2, 1, 0, 0, 0, 0);
    check("R3 byte ptr", host_rdata, exp_byte_ptr(p));
    check("R4 ack", remote_ack, 1);
    @(negedge clk);
    check("R4 ack one cycle", remote_ack, 0);
    bus(2'd0, 1, 0, 0, 0, 0);
    check("R4 flag cleared", host_rdata, 0);
  endtask

  task automatic t_ie();
    logic [17:0] p;
    p = 18'h3FFFF;
    bus(2'd0, 0, 1, 0, 0, 16'h0040);
    check("R5 IE no flag no irq", host_irq, 0);
    post(p);
    check("R2 irq with IE", host_irq, 1);
    bus(2'd0, 0, 1, 0, 0, 16'hFFBF);
    check("R5 IE=0 drops irq", host_irq, 0);
    bus(2'd0, 1, 0, 0, 0, 0);
    check("R5 only IE changed", host_rdata, 16'h0080);
    bus(2'd0, 0, 1, 1, 1, 16'hFFFF);
    check("R5 odd byte no effect irq", host_irq, 0);
    bus(2'd0, 1, 0, 0, 0, 0);
    check("R5 odd byte no effect csr", host_rdata, 16'h0080);
    bus(2'd0, 0, 1, 0, 0, 16'h0040);
    check("R5 IE=1 with flag raises", host_irq, 1);
    bus(2'd2, 1, 0, 0, 0, 0);
    check("R3 all-ones ptr", host_rdata, exp_byte_ptr(p));
    check("R4 irq cleared", host_irq, 0);
    bus(2'd0, 0, 1, 0, 0, 16'h0000);
  endtask

  task automatic t_vectors();
    bus(2'd1, 0, 1, 0, 0, 16'h1234);
    check("R6 word l3", {req3_valid, req3_vec}, {1'b1, 8'h12});
    check("R6 word l2", {req2_valid, req2_vec}, {1'b1, 8'h34});
    @(negedge clk);
    check("R6 one cycle", {req2_valid, req3_valid}, 0);
    bus(2'd1, 0, 1, 1, 1, 16'hA55A);
    check("R6 odd l3", {req3_valid, req3_vec}, {1'b1, 8'hA5});
    check("R6 odd no l2", req2_valid, 0);
    bus(2'd1, 0, 1, 1, 0, 16'hC37E);
    check("R6 even l2", {req2_valid, req2_vec}, {1'b1, 8'h7E});
    check("R6 even no l3", req3_valid, 0);
  endtask

  task automatic t_held_post();
    @(negedge clk);
    post_in = 1'b1; post_ptr = 18'h00155;
    repeat (4) @(negedge clk);
    bus(2'd2, 1, 0, 0, 0, 0);
    check("R7 ptr", host_rdata, exp_byte_ptr(18'h00155));
    repeat (3) @(negedge clk);
    bus(2'd0, 1, 0, 0, 0, 0);
    check("R7 no second set", host_rdata, 0);
    post_in = 1'b0;
  endtask

  task automatic t_collision();
    post(18'h01000);
    @(negedge clk);
    post_in = 1'b1; post_ptr = 18'h02000;
    host_sel = 2'd2; host_rd = 1'b1;
    @(negedge clk);
    host_rd = 1'b0; post_in = 1'b0;
    check("R8 old ptr returned", host_rdata, exp_byte_ptr(18'h01000));
    check("R8 ack", remote_ack, 1);
    bus(2'd0, 1, 0, 0, 0, 0);
    check("R8 flag kept", host_rdata, 16'h0080);
    bus(2'd2, 1, 0, 0, 0, 0);
    check("R8 new ptr", host_rdata, exp_byte_ptr(18'h02000));
  endtask

  task automatic t_nxm();
    bus(2'd3, 1, 0, 0, 0, 0);
    check("R9 read err", host_err, 1);
    @(negedge clk);
    check("R9 err one cycle", host_err, 0);
    bus(2'd3, 0, 1, 0, 0, 16'hFFFF);
    check("R9 write err", host_err, 1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_post_read();
    t_ie();
    t_vectors();
    t_held_post();
    t_collision();
    t_nxm();
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    #2000000;
    if (!done) begin
      n_tests++;
      n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end
endmodule